// File: doc/BRIEF.md
# Down-Counting Timer, Event Counter and PWM Unit

This block is a 16-bit counter that only counts down. It can serve as a periodic timer, as an event counter or as a PWM generator. On each advance it steps down by one. When it reaches zero it loads the period value again and gives a one-cycle terminal-count pulse. A separate strobe input may stand in for the system clock as the count advance, so external events can be counted.

A comparator checks the live count against a programmable level, using one of five relations. Its result drives three outputs:
- a plain compare output;
- a true PWM output;
- a complementary PWM output.

A programmable dead time separates the true and complementary outputs after each compare edge. A kill input forces all three outputs low at once. A capture strobe copies the live count into a capture register. Three sticky events (terminal count, compare rising, capture) feed one maskable interrupt line.

Software uses a small register port with single-cycle writes and combinational reads. Through it, software sets the period, compare level, configuration and dead time. It issues start and stop commands, and reads back the live count, the captured value and the event status. Reading the status clears it.

Top module: `dctimer_pwm`

## Requirements
- R1: After the active-low reset:
  - all registers, the count and the event status read as zero;
  - the unit is idle;
  - `tc_o`, `irq_o`, `cmp_o` and `pwm_o` are low;
  - `pwm_n_o` is high.
- R2: Each advance lowers the count by one. An advance taken at count zero loads the period instead. `tc_o` is high for exactly the one cycle that follows that advance.
- R3: Writing address 4 with bit 0 set (start) loads the period and sets the unit running. Writing address 4 with bit 1 set (stop) halts the count where it is. A high on `reload_i` loads the period without changing the running state. Start and reload take priority over counting, and an advance suppressed this way gives no terminal count.
- R4: Configuration bits [2:0] select the compare relation of the count against the compare level: 0 less-than, 1 less-or-equal, 2 equal, 3 greater-or-equal, 4 greater-than. Codes 5 to 7 are never true. The compare result is low while the unit is idle, and `cmp_o` shows it whenever kill is low.
- R5: Configuration bits [4:3] select the run mode:
  - 0: free running;
  - 1: one-shot, in which the terminal count reloads the period and then stops the unit;
  - 2: advance only while `enable_i` is high;
  - 3: the same as free running.
- R6: With configuration bit 5 clear the count advances every clock. With it set, the count advances only in cycles where `tick_i` is high.
- R7: In a cycle with `capture_i` high, the count at that clock edge is stored. Address 6 reads it.
- R8: Each change of the compare result starts a dead time of D cycles, where D is the value at address 3 (0 to 255). The dead time counts the cycle of the change itself. During it, `pwm_o` and `pwm_n_o` are both low. Outside it, `pwm_o` equals the compare result and `pwm_n_o` its inverse.
- R9: While `kill_i` is high, `cmp_o`, `pwm_o` and `pwm_n_o` are low in the same cycle.
- R10: Status at address 7 holds sticky bits: bit 0 terminal count, bit 1 rising compare, bit 2 capture. A read of address 7 clears them, but an event in the same cycle wins. `irq_o` is high when any status bit is set whose mask bit is set (configuration bits [8:6], in the same order).
- R11: Address 5 returns the live count in every cycle, including while counting.
- R12: Register map:

  | Address | Access | Contents |
  |---|---|---|
  | 0 | read/write | period |
  | 1 | read/write | compare level |
  | 2 | read/write | configuration, bits [8:0] |
  | 3 | read/write | dead time |
  | 4 | write: commands; read: bit 0 = running | control |
  | 5 | read-only | live count |
  | 6 | read-only | captured value |
  | 7 | read, clears on read | status |

  Written values take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 7) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tick_i | input | 1 | External count-advance strobe |
| reload_i | input | 1 | Load period into the counter |
| enable_i | input | 1 | Count gate for run mode 2 |
| capture_i | input | 1 | Capture strobe |
| kill_i | input | 1 | Force compare outputs low |
| cmp_o | output | 1 | Compare result, killable |
| pwm_o | output | 1 | True PWM output with dead time |
| pwm_n_o | output | 1 | Complementary PWM output with dead time |
| tc_o | output | 1 | Terminal-count pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on three conditions:
- only one register access happens per cycle;
- start and stop are not written in the same word;
- a change of the period register reaches the count only through a load, so every change of the count is either a step of one or a load of the previous cycle's period.

The stimulus keeps within these conditions. It changes inputs only just after the falling edge and issues register accesses strictly one at a time. It runs every compare code, including the three unused ones, and every run mode. It toggles kill, capture, reload and the tick strobe in patterns that overlap compare edges, and it places a status read in the same cycle as a capture event.

// File: rtl/dctimer_pkg.sv
`timescale 1ns/1ps
// Shared register addresses, comparator codes, run modes and the
// configuration word layout for the down-counting timer/PWM unit.
package dctimer_pkg;
    localparam logic [2:0] A_PERIOD  = 3'd0;
    localparam logic [2:0] A_COMPARE = 3'd1;
    localparam logic [2:0] A_CONFIG  = 3'd2;
    localparam logic [2:0] A_DEAD    = 3'd3;
    localparam logic [2:0] A_CTRL    = 3'd4;
    localparam logic [2:0] A_COUNT   = 3'd5;
    localparam logic [2:0] A_CAPT    = 3'd6;
    localparam logic [2:0] A_STATUS  = 3'd7;

    localparam logic [2:0] CMP_LT = 3'd0;
    localparam logic [2:0] CMP_LE = 3'd1;
    localparam logic [2:0] CMP_EQ = 3'd2;
    localparam logic [2:0] CMP_GE = 3'd3;
    localparam logic [2:0] CMP_GT = 3'd4;

    typedef enum logic [1:0] {
        RUN_FREE     = 2'd0,
        RUN_ONCE     = 2'd1,
        RUN_GATED    = 2'd2,
        RUN_FREE_ALT = 2'd3
    } run_mode_e;

    // Packed from MSB: mask[8:6] {cap,cmp,tc}, tick_sel[5], run[4:3], cmp[2:0]
    typedef struct packed {
        logic [2:0] irq_mask;
        logic       tick_sel;
        run_mode_e  run_mode;
        logic [2:0] cmp_mode;
    } cfg_t;
endpackage

// File: rtl/dctimer_counter.sv
`timescale 1ns/1ps
// Down counter with period reload and run control.
// Assumes start and stop are never asserted together; start and reload
// take priority over an advance, which then yields no terminal count.
module dctimer_counter
    import dctimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             reload,
    input  logic             tick,
    input  logic             gate,
    input  run_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             tc_evt
);
    logic advance;
    logic at_zero;

    // Decide whether this cycle advances and whether it ends a period.
    always_comb begin
        advance = running && tick && ((mode != RUN_GATED) || gate);
        at_zero = (count == '0);
        tc_evt  = advance && at_zero && !start && !reload;
    end

    // Count value: load on start/reload/zero, otherwise step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start || reload) begin
            count <= period;
        end else if (advance) begin
            count <= at_zero ? period : count - 1'b1;
        end
    end

    // Running flag: set by start, cleared by stop or one-shot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (tc_evt && (mode == RUN_ONCE)) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/dctimer_compare.sv
`timescale 1ns/1ps
// Comparator: relates the count to the compare level by one of five
// relations. Unused codes are never true; idle forces the result low.
module dctimer_compare
    import dctimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic [2:0]       mode,
    input  logic             running,
    output logic             raw
);
    logic below;
    logic equal;
    logic hit;

    // Evaluate the selected relation and gate it with the running state.
    always_comb begin
        below = (count < level);
        equal = (count == level);
        case (mode)
            CMP_LT:  hit = below;
            CMP_LE:  hit = below || equal;
            CMP_EQ:  hit = equal;
            CMP_GE:  hit = !below;
            CMP_GT:  hit = !below && !equal;
            default: hit = 1'b0;
        endcase
        raw = running && hit;
    end
endmodule

// File: rtl/dctimer_deadband.sv
`timescale 1ns/1ps
// Complementary output stage with dead time and kill.
// Each change of the raw compare holds both outputs low for DEAD cycles,
// counting the cycle of the change itself. Kill acts combinationally.
module dctimer_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic            kill,
    input  logic [DB_W-1:0] dead,
    output logic            pwm_p,
    output logic            pwm_n,
    output logic            raw_rise
);
    logic            raw_q;
    logic [DB_W-1:0] left;
    logic            change;
    logic            hold;

    // Detect compare edges and decide whether the dead time is active.
    always_comb begin
        change   = raw ^ raw_q;
        hold     = change ? (dead != '0) : (left != '0);
        raw_rise = raw && !raw_q;
        pwm_p    = !kill && !hold && raw;
        pwm_n    = !kill && !hold && !raw;
    end

    // Remember the last compare value and run down the dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            left  <= '0;
        end else begin
            raw_q <= raw;
            if (change) begin
                left <= (dead == '0) ? '0 : dead - 1'b1;
            end else if (left != '0) begin
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dctimer_pwm.sv
`timescale 1ns/1ps
// Top of the down-counting timer/counter/PWM unit: register port,
// capture register, sticky status with interrupt, and the three datapath
// blocks. Assumes at most one register access per cycle and CNT_W no
// smaller than the configuration word.
module dctimer_pwm
    import dctimer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic             enable_i,
    input  logic             capture_i,
    input  logic             kill_i,
    output logic             cmp_o,
    output logic             pwm_o,
    output logic             pwm_n_o,
    output logic             tc_o,
    output logic             irq_o
);
    localparam int CFG_W = $bits(cfg_t);
    localparam int EV_N  = 3;

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] level_q;
    cfg_t             cfg_q;
    logic [DB_W-1:0]  dead_q;
    logic [CNT_W-1:0] capt_q;
    logic [EV_N-1:0]  status_q;
    logic [EV_N-1:0]  events;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             tc_evt;
    logic             raw;
    logic             raw_rise;
    logic             start;
    logic             stop;
    logic             stat_rd;
    logic             tick;

    // Decode commands and select the count-advance source.
    always_comb begin
        start   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
        stop    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];
        stat_rd = reg_rd && (reg_addr == A_STATUS);
        tick    = cfg_q.tick_sel ? tick_i : 1'b1;
        events  = {capture_i, raw_rise, tc_evt};
    end

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            level_q  <= '0;
            cfg_q    <= '0;
            dead_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_PERIOD:  period_q <= reg_wdata;
                A_COMPARE: level_q  <= reg_wdata;
                A_CONFIG:  cfg_q    <= cfg_t'(reg_wdata[CFG_W-1:0]);
                A_DEAD:    dead_q   <= reg_wdata[DB_W-1:0];
                default:   ;
            endcase
        end
    end

    // Capture register and registered terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capt_q <= '0;
            tc_o   <= 1'b0;
        end else begin
            if (capture_i) capt_q <= count;
            tc_o <= tc_evt;
        end
    end

    // One sticky status bit per event; a set in the read cycle wins.
    for (genvar i = 0; i < EV_N; i++) begin : g_status
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else begin
                status_q[i] <= (status_q[i] && !stat_rd) || events[i];
            end
        end
    end

    // Combinational read mux and interrupt request.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_PERIOD:  reg_rdata = period_q;
            A_COMPARE: reg_rdata = level_q;
            A_CONFIG:  reg_rdata[CFG_W-1:0] = cfg_q;
            A_DEAD:    reg_rdata[DB_W-1:0] = dead_q;
            A_CTRL:    reg_rdata[0] = running;
            A_COUNT:   reg_rdata = count;
            A_CAPT:    reg_rdata = capt_q;
            default:   reg_rdata[EV_N-1:0] = status_q;
        endcase
        irq_o = |(status_q & cfg_q.irq_mask);
        cmp_o = raw && !kill_i;
    end

    dctimer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .reload  (reload_i),
        .tick    (tick),
        .gate    (enable_i),
        .mode    (cfg_q.run_mode),
        .period  (period_q),
        .count   (count),
        .running (running),
        .tc_evt  (tc_evt)
    );

    dctimer_compare #(.CNT_W(CNT_W)) u_compare (
        .count   (count),
        .level   (level_q),
        .mode    (cfg_q.cmp_mode),
        .running (running),
        .raw     (raw)
    );

    dctimer_deadband #(.DB_W(DB_W)) u_deadband (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .kill     (kill_i),
        .dead     (dead_q),
        .pwm_p    (pwm_o),
        .pwm_n    (pwm_n_o),
        .raw_rise (raw_rise)
    );
endmodule

// File: rtl/dctimer_pwm_chk.sv
`timescale 1ns/1ps
// Property checker for dctimer_pwm, attached by bind. Relates the count,
// running state, status and outputs across cycles.
module dctimer_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tc_o,
    input logic             cmp_o,
    input logic             pwm_o,
    input logic             pwm_n_o,
    input logic             kill_i,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic [1:0]       run_mode,
    input logic [2:0]       status,
    input logic             stat_rd
);
    AST_TC_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> ($past(count) == '0));  // R2

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((count != $past(count)) && (count != $past(period)))
            |-> (count == $past(count) - 1'b1));  // R2

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && ($past(run_mode) == 2'd1)) |-> !running);  // R5

    AST_CMP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> running);  // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_o && pwm_n_o));  // R8

    AST_KILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |-> (!cmp_o && !pwm_o && !pwm_n_o));  // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_rd) |-> ((status & $past(status)) == $past(status)));  // R10
endmodule

bind dctimer_pwm dctimer_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_o     (tc_o),
    .cmp_o    (cmp_o),
    .pwm_o    (pwm_o),
    .pwm_n_o  (pwm_n_o),
    .kill_i   (kill_i),
    .running  (running),
    .count    (count),
    .period   (period_q),
    .run_mode (cfg_q.run_mode),
    .status   (status_q),
    .stat_rd  (stat_rd)
);

// File: tb/dctimer_pwm_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is stepped every clock and
// compared with all outputs; directed checks cover the boundary cases.
module dctimer_pwm_test;
    import dctimer_pkg::*;

    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [2:0]    reg_addr = A_COUNT;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          tick_i = 1'b0, reload_i = 1'b0, enable_i = 1'b0;
    logic          capture_i = 1'b0, kill_i = 1'b0;
    logic          cmp_o, pwm_o, pwm_n_o, tc_o, irq_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    // Reference model state
    logic [CW-1:0] m_per = '0, m_lvl = '0, m_cnt = '0, m_cap = '0;
    logic [2:0]    m_cm = '0, m_mask = '0, m_st = '0;
    logic [1:0]    m_rm = '0;
    logic          m_ts = 1'b0, m_run = 1'b0, m_tc = 1'b0, m_rawq = 1'b0;
    logic [DW-1:0] m_db = '0, m_left = '0;

    always #2 clk = ~clk;

    dctimer_pwm #(.CNT_W(CW), .DB_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_i(tick_i), .reload_i(reload_i), .enable_i(enable_i),
        .capture_i(capture_i), .kill_i(kill_i), .cmp_o(cmp_o),
        .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .tc_o(tc_o), .irq_o(irq_o)
    );

    function automatic logic m_raw();
        logic hit;
        case (m_cm)
            3'd0: hit = m_cnt < m_lvl;
            3'd1: hit = m_cnt <= m_lvl;
            3'd2: hit = m_cnt == m_lvl;
            3'd3: hit = m_cnt >= m_lvl;
            3'd4: hit = m_cnt > m_lvl;
            default: hit = 1'b0;
        endcase
        return m_run && hit;
    endfunction

    function automatic logic m_hold();
        return (m_raw() != m_rawq) ? (m_db != 0) : (m_left != 0);
    endfunction

    function automatic logic [CW-1:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_per;
            3'd1: return m_lvl;
            3'd2: return {7'd0, m_mask, m_ts, m_rm, m_cm};
            3'd3: return {8'd0, m_db};
            3'd4: return {15'd0, m_run};
            3'd5: return m_cnt;
            3'd6: return m_cap;
            default: return {13'd0, m_st};
        endcase
    endfunction

    task automatic chk(input string what, input string req,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs, then advance the model by one clock.
    task automatic step(input bit waited = 1'b0);
        logic raw, adv, strt, stp, tcev, tk;
        logic [CW-1:0] n_cnt;
        logic n_run;
        logic [DW-1:0] n_left;
        logic [2:0] n_st;
        if (!waited) #1;
        raw = m_raw();
        chk("cmp_o", kill_i ? "R9" : "R4", cmp_o, raw && !kill_i);
        chk("pwm_o", "R8", pwm_o, !kill_i && !m_hold() && raw);
        chk("pwm_n_o", "R8", pwm_n_o, !kill_i && !m_hold() && !raw);
        chk("tc_o", "R2", tc_o, m_tc);
        chk("irq_o", "R10", irq_o, |(m_st & m_mask));
        chk("reg_rdata", cur_req, reg_rdata, m_rd(reg_addr));
        tk   = m_ts ? tick_i : 1'b1;
        adv  = m_run && tk && (m_rm != 2'd2 || enable_i);
        strt = reg_wr && reg_addr == 3'd4 && reg_wdata[0];
        stp  = reg_wr && reg_addr == 3'd4 && reg_wdata[1];
        tcev = adv && m_cnt == 0 && !strt && !reload_i;
        n_cnt = (strt || reload_i) ? m_per : (adv ? (m_cnt == 0 ? m_per : m_cnt - 1) : m_cnt);
        n_run = strt ? 1'b1 : (stp ? 1'b0 : ((tcev && m_rm == 2'd1) ? 1'b0 : m_run));
        n_left = (raw != m_rawq) ? ((m_db == 0) ? '0 : m_db - 1) : ((m_left != 0) ? m_left - 1 : '0);
        n_st = ((reg_rd && reg_addr == 3'd7) ? 3'd0 : m_st) | {capture_i, raw && !m_rawq, tcev};
        @(posedge clk);
        if (capture_i) m_cap = m_cnt;
        m_cnt = n_cnt; m_run = n_run; m_left = n_left; m_st = n_st;
        m_tc = tcev; m_rawq = raw;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_per = reg_wdata;
                3'd1: m_lvl = reg_wdata;
                3'd2: begin
                    m_cm = reg_wdata[2:0]; m_rm = reg_wdata[4:3];
                    m_ts = reg_wdata[5];   m_mask = reg_wdata[8:6];
                end
                3'd3: m_db = reg_wdata[DW-1:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = A_COUNT;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_rd = 1'b1; reg_addr = a;
        step();
        reg_rd = 1'b0; reg_addr = A_COUNT;
    endtask

    // Directed read check with a literal expectation, then one clock.
    task automatic peek(input logic [2:0] a, input string req, input logic [CW-1:0] exp);
        reg_addr = a;
        #1;
        chk("directed read", req, reg_rdata, exp);
        step(1'b1);
        reg_addr = A_COUNT;
    endtask

    function automatic logic [CW-1:0] cfgw(input int cm, input int rm, input int ts, input int mask);
        return CW'((mask << 6) | (ts << 5) | (rm << 3) | cm);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        #1;
        chk("pwm_n_o after reset", "R1", pwm_n_o, 1'b1);
        chk("pwm_o after reset", "R1", pwm_o, 1'b0);
        step(1'b1);
        peek(A_COUNT, "R1", 0);
        peek(A_CONFIG, "R1", 0);
        // R12 register map, R3 start, R11 live count, R2 wrap
        cur_req = "R12";
        wr(A_PERIOD, 5); wr(A_COMPARE, 3); wr(A_CONFIG, cfgw(0, 0, 0, 0)); wr(A_DEAD, 0);
        peek(A_PERIOD, "R12", 5);
        peek(A_COMPARE, "R12", 3);
        cur_req = "R3";
        wr(A_CTRL, 1);
        peek(A_COUNT, "R3", 5);
        peek(A_COUNT, "R11", 4);
        cur_req = "R2";
        idle(20);
        // R4 every comparator code, unused ones included
        cur_req = "R4";
        for (int m = 0; m < 8; m++) begin
            wr(A_CONFIG, cfgw(m, 0, 0, 0));
            idle(8);
        end
        // R8 dead time
        cur_req = "R8";
        wr(A_CONFIG, cfgw(3, 0, 0, 0));
        wr(A_DEAD, 2); idle(14);
        wr(A_COMPARE, 1); wr(A_DEAD, 3); idle(14);
        // R9 kill
        cur_req = "R9";
        kill_i = 1'b1;
        #1;
        chk("pwm_o under kill", "R9", pwm_o, 1'b0);
        chk("pwm_n_o under kill", "R9", pwm_n_o, 1'b0);
        chk("cmp_o under kill", "R9", cmp_o, 1'b0);
        step(1'b1);
        idle(5); kill_i = 1'b0; idle(3);
        // R3 reload and stop
        cur_req = "R3";
        reload_i = 1'b1; step(); reload_i = 1'b0; idle(4);
        wr(A_CTRL, 2); idle(3);
        peek(A_CTRL, "R3", 0);
        // R6 external advance strobe
        cur_req = "R6";
        wr(A_CONFIG, cfgw(0, 0, 1, 0)); wr(A_PERIOD, 4); wr(A_CTRL, 1);
        idle(5);
        peek(A_COUNT, "R6", 4);
        for (int i = 0; i < 14; i++) begin
            tick_i = (i % 3) != 0;
            step();
        end
        tick_i = 1'b0;
        // R5 run modes
        cur_req = "R5";
        wr(A_CONFIG, cfgw(0, 1, 0, 0)); wr(A_PERIOD, 3); wr(A_CTRL, 1);
        idle(12);
        peek(A_CTRL, "R5", 0);
        peek(A_COUNT, "R5", 3);
        wr(A_CONFIG, cfgw(2, 2, 0, 0)); wr(A_CTRL, 1);
        for (int i = 0; i < 16; i++) begin
            enable_i = (i % 4) < 2;
            step();
        end
        enable_i = 1'b0;
        wr(A_CONFIG, cfgw(1, 3, 0, 0)); wr(A_CTRL, 1); idle(10);
        // R7 capture with R10 interrupt mask
        cur_req = "R7";
        wr(A_CTRL, 2); rd(A_STATUS);
        wr(A_CONFIG, cfgw(0, 0, 0, 4)); wr(A_PERIOD, 9); wr(A_CTRL, 1);
        capture_i = 1'b1; step(); capture_i = 1'b0;
        reg_addr = A_CAPT;
        #1;
        chk("irq after capture", "R10", irq_o, 1'b1);
        chk("captured count", "R7", reg_rdata, 9);
        step(1'b1);
        reg_addr = A_COUNT;
        // R10 clear on read, and set wins over clear
        cur_req = "R10";
        wr(A_CTRL, 2); rd(A_STATUS);
        peek(A_STATUS, "R10", 0);
        capture_i = 1'b1; rd(A_STATUS); capture_i = 1'b0;
        peek(A_STATUS, "R10", 4);
        // Mixed run
        cur_req = "R11";
        wr(A_DEAD, 1); wr(A_CONFIG, cfgw(3, 0, 0, 7));
        wr(A_PERIOD, 6); wr(A_COMPARE, 3); wr(A_CTRL, 1);
        for (int i = 0; i < 40; i++) begin
            kill_i    = (i % 11) == 5;
            capture_i = (i % 7) == 2;
            reg_rd    = (i % 9) == 4;
            reg_addr  = reg_rd ? A_STATUS : A_COUNT;
            step();
        end
        kill_i = 1'b0; capture_i = 1'b0; reg_rd = 1'b0; reg_addr = A_COUNT;
        idle(4);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule